// File: doc/BRIEF.md
# Single-Message Blocking Channel Bank

This block is a bank of inter-task message channels. Each channel has room for exactly one message. A task sends with an Out request and receives with an In request. Every request names a channel index, the requesting task's identifier and, for Out, a data word. A request that cannot finish is recorded in that channel as a blocked task. When a later request lets the blocked task complete, the bank emits a wake-up event that carries the blocked task's identifier. The scheduler that puts woken tasks back on a run queue sits outside this block.

Because a channel holds at most one message, it also works as a mutual-exclusion lock. A task takes a resource by sending Out to the resource's channel and gives it back with In. While the resource is held, any other Out to that channel blocks. Such a lock should only be shared among tasks of the same priority level.

Each channel is a four-state machine. CH_EMPTY means no message and no waiter. CH_HELD means one message and no waiter. CH_READER_WAIT means no message and one blocked reader. CH_WRITERS_WAIT means one message and one or more blocked writers, kept in arrival order.

The transitions are:
- Out in CH_EMPTY goes to CH_HELD.
- In in CH_EMPTY goes to CH_READER_WAIT.
- Out in CH_READER_WAIT goes to CH_EMPTY (hand-off).
- In in CH_HELD goes to CH_EMPTY (release).
- Out in CH_HELD goes to CH_WRITERS_WAIT.
- Out in CH_WRITERS_WAIT stays there (another writer is queued).
- In in CH_WRITERS_WAIT refills the channel from the oldest writer. It stays in CH_WRITERS_WAIT, or goes to CH_HELD when the last writer leaves.

Top module: `msgchan_bank`

## Requirements
- R1: An Out to a channel in CH_EMPTY completes with outcome done. The channel stores the word and its `ch_full` bit becomes 1.
- R2: An Out to a full channel whose writer queue has room gets outcome blocked. The stored message is unchanged and the writer is queued.
- R3: An In to a full channel with no queued writers completes with outcome done and returns the stored word on `resp_data`. The channel becomes empty.
- R4: An In to an empty channel with no waiting reader gets outcome blocked. The reader is recorded and the channel's `ch_waiter` bit becomes 1.
- R5: An Out to a channel with a waiting reader completes with outcome done. It emits a wake-up for that reader with the sent word on `wake_data`. The channel stays empty and its waiter bit clears.
- R6: An In to a full channel with queued writers returns the stored word. The oldest queued writer's word becomes the stored message, and that writer is woken with `wake_data` = 0. Writers leave the queue in the order they arrived.
- R7: A request whose channel index is NUM_CH or higher gets outcome error. It changes no channel state.
- R8: Two cases get outcome error and change no state: an Out to a full channel whose writer queue already holds WQ_DEPTH writers, and an In to a channel that already has a waiting reader.
- R9: Each valid request produces exactly one of done, blocked or error, in the cycle after it is sampled. At most one wake-up is produced per cycle, and only together with a done outcome.
- R10: After reset, every channel is empty with no waiters, and all response and wake-up outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is presented this cycle |
| req_out | input | 1 | 1 = Out (send), 0 = In (receive) |
| req_ch | input | $clog2(NUM_CH)+1 | Channel index; NUM_CH or higher is invalid |
| req_tid | input | TID_W | Identifier of the requesting task |
| req_data | input | DATA_W | Word to send (Out only) |
| resp_valid | output | 1 | Outcome of the previous cycle's request |
| resp_done | output | 1 | The request completed |
| resp_blocked | output | 1 | The requester is descheduled and recorded |
| resp_err | output | 1 | The request was refused with no state change |
| resp_data | output | DATA_W | Word received by a completed In, otherwise 0 |
| wake_valid | output | 1 | A blocked task may now run |
| wake_tid | output | TID_W | Identifier of the woken task |
| wake_data | output | DATA_W | Word delivered to a woken reader; 0 for a woken writer |
| ch_full | output | NUM_CH | Per-channel message-present flag |
| ch_waiter | output | NUM_CH | Per-channel blocked-task-present flag |

## Verification
The main function is exercised with several distinct patterns, each of which separates a different class of fault:
- A send followed by a plain receive separates storing a message from freeing the slot.
- A pile of writers on one channel, drained by successive receives, shows whether hand-over follows arrival order and whether the queue limit is enforced.
- A receive posted before its send tells the direct reader hand-off apart from ordinary storage.
- A lock pattern (acquire, contend, release) and requests with invalid indices show that refusals leave the state untouched.
- A long random mix across all channels, including invalid indices, is compared every cycle against a behavioural model. It catches faults in how channels interact and in the output multiplexing.

// File: rtl/msgchan_pkg.sv
package msgchan_pkg;

    typedef enum logic [1:0] {
        CH_EMPTY        = 2'd0,
        CH_HELD         = 2'd1,
        CH_READER_WAIT  = 2'd2,
        CH_WRITERS_WAIT = 2'd3
    } ch_state_t;

endpackage

// File: rtl/msgchan_wq.sv
module msgchan_wq #(
    parameter int DEPTH = 2,
    parameter int W     = 12
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push,
    input  logic [W-1:0]                   push_word,
    input  logic                           pop,
    output logic [W-1:0]                   head_word,
    output logic [$clog2(DEPTH+1)-1:0]     cnt,
    output logic                           full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            if (push && !pop)      cnt <= cnt + CW'(1);
            else if (pop && !push) cnt <= cnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_word;
    end

    assign head_word = mem[rd_ptr];
    assign full      = (cnt == CW'(DEPTH));

    p_no_push_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);
    p_no_pop_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> !pop);

endmodule

// File: rtl/msgchan_slot.sv
module msgchan_slot
    import msgchan_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int TID_W    = 4,
    parameter int WQ_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              is_out,
    input  logic [TID_W-1:0]  tid,
    input  logic [DATA_W-1:0] data,
    output logic              o_done,
    output logic              o_blocked,
    output logic              o_err,
    output logic [DATA_W-1:0] o_rdata,
    output logic              o_wake,
    output logic [TID_W-1:0]  o_wake_tid,
    output logic [DATA_W-1:0] o_wake_data,
    output logic              full,
    output logic              waiter
);
    localparam int WW = TID_W + DATA_W;
    localparam int CW = $clog2(WQ_DEPTH + 1);

    ch_state_t         st, st_nx;
    logic [DATA_W-1:0] held, held_nx;
    logic [TID_W-1:0]  rd_tid, rd_tid_nx;

    logic              wq_push, wq_pop, wq_full;
    logic [WW-1:0]     wq_head;
    logic [CW-1:0]     wq_cnt;
    logic [TID_W-1:0]  head_tid;
    logic [DATA_W-1:0] head_data;

    assign head_tid  = wq_head[WW-1:DATA_W];
    assign head_data = wq_head[DATA_W-1:0];

    msgchan_wq #(.DEPTH(WQ_DEPTH), .W(WW)) u_wq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wq_push),
        .push_word ({tid, data}),
        .pop       (wq_pop),
        .head_word (wq_head),
        .cnt       (wq_cnt),
        .full      (wq_full)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= CH_EMPTY;
            held   <= '0;
            rd_tid <= '0;
        end else begin
            st     <= st_nx;
            held   <= held_nx;
            rd_tid <= rd_tid_nx;
        end
    end

    // next state
    always_comb begin
        st_nx     = st;
        held_nx   = held;
        rd_tid_nx = rd_tid;
        wq_push   = 1'b0;
        wq_pop    = 1'b0;
        if (sel) begin
            unique case (st)
                CH_EMPTY: begin
                    if (is_out) begin
                        st_nx   = CH_HELD;
                        held_nx = data;
                    end else begin
                        st_nx     = CH_READER_WAIT;
                        rd_tid_nx = tid;
                    end
                end
                CH_READER_WAIT: begin
                    if (is_out) st_nx = CH_EMPTY;
                end
                CH_HELD: begin
                    if (is_out) begin
                        wq_push = 1'b1;
                        st_nx   = CH_WRITERS_WAIT;
                    end else begin
                        st_nx = CH_EMPTY;
                    end
                end
                CH_WRITERS_WAIT: begin
                    if (is_out) begin
                        wq_push = !wq_full;
                    end else begin
                        wq_pop  = 1'b1;
                        held_nx = head_data;
                        if (wq_cnt == CW'(1)) st_nx = CH_HELD;
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        o_done      = 1'b0;
        o_blocked   = 1'b0;
        o_err       = 1'b0;
        o_rdata     = '0;
        o_wake      = 1'b0;
        o_wake_tid  = '0;
        o_wake_data = '0;
        if (sel) begin
            unique case (st)
                CH_EMPTY: begin
                    o_done    = is_out;
                    o_blocked = !is_out;
                end
                CH_READER_WAIT: begin
                    if (is_out) begin
                        o_done      = 1'b1;
                        o_wake      = 1'b1;
                        o_wake_tid  = rd_tid;
                        o_wake_data = data;
                    end else begin
                        o_err = 1'b1;
                    end
                end
                CH_HELD: begin
                    if (is_out) begin
                        o_blocked = 1'b1;
                    end else begin
                        o_done  = 1'b1;
                        o_rdata = held;
                    end
                end
                CH_WRITERS_WAIT: begin
                    if (is_out) begin
                        o_err     = wq_full;
                        o_blocked = !wq_full;
                    end else begin
                        o_done     = 1'b1;
                        o_rdata    = held;
                        o_wake     = 1'b1;
                        o_wake_tid = head_tid;
                    end
                end
            endcase
        end
    end

    assign full   = (st == CH_HELD) || (st == CH_WRITERS_WAIT);
    assign waiter = (st == CH_READER_WAIT) || (st == CH_WRITERS_WAIT);

    p_fill_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && is_out && st == CH_EMPTY) |=> (st == CH_HELD && held == $past(data)));
    p_writer_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && is_out && st == CH_HELD) |=> (st == CH_WRITERS_WAIT && $stable(held)));
    p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !is_out && st == CH_HELD) |=> (st == CH_EMPTY));
    p_reader_rec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !is_out && st == CH_EMPTY) |=> (st == CH_READER_WAIT && rd_tid == $past(tid)));
    p_handoff_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && is_out && st == CH_READER_WAIT) |=> (st == CH_EMPTY));
    p_refill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !is_out && st == CH_WRITERS_WAIT) |=> full);
    p_reader_twice_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !is_out && st == CH_READER_WAIT) |=> (st == CH_READER_WAIT && $stable(rd_tid)));

endmodule

// File: rtl/msgchan_bank.sv
module msgchan_bank #(
    parameter int NUM_CH   = 4,
    parameter int DATA_W   = 8,
    parameter int TID_W    = 4,
    parameter int WQ_DEPTH = 2,
    localparam int CH_W    = $clog2(NUM_CH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_out,
    input  logic [CH_W-1:0]   req_ch,
    input  logic [TID_W-1:0]  req_tid,
    input  logic [DATA_W-1:0] req_data,
    output logic              resp_valid,
    output logic              resp_done,
    output logic              resp_blocked,
    output logic              resp_err,
    output logic [DATA_W-1:0] resp_data,
    output logic              wake_valid,
    output logic [TID_W-1:0]  wake_tid,
    output logic [DATA_W-1:0] wake_data,
    output logic [NUM_CH-1:0] ch_full,
    output logic [NUM_CH-1:0] ch_waiter
);
    logic                           idx_ok;
    logic [NUM_CH-1:0]              sel, s_done, s_blk, s_err, s_wake;
    logic [NUM_CH-1:0][DATA_W-1:0]  s_rdata, s_wdata;
    logic [NUM_CH-1:0][TID_W-1:0]   s_wtid;

    logic              any_done, any_blk, any_err, any_wake;
    logic [DATA_W-1:0] mux_rdata, mux_wdata;
    logic [TID_W-1:0]  mux_wtid;

    assign idx_ok = (req_ch < CH_W'(NUM_CH));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign sel[i] = req_valid && idx_ok && (req_ch == CH_W'(i));
        msgchan_slot #(.DATA_W(DATA_W), .TID_W(TID_W), .WQ_DEPTH(WQ_DEPTH)) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .sel         (sel[i]),
            .is_out      (req_out),
            .tid         (req_tid),
            .data        (req_data),
            .o_done      (s_done[i]),
            .o_blocked   (s_blk[i]),
            .o_err       (s_err[i]),
            .o_rdata     (s_rdata[i]),
            .o_wake      (s_wake[i]),
            .o_wake_tid  (s_wtid[i]),
            .o_wake_data (s_wdata[i]),
            .full        (ch_full[i]),
            .waiter      (ch_waiter[i])
        );
    end

    // unselected slots drive zeros, so an OR merge picks the active one
    always_comb begin
        any_done  = |s_done;
        any_blk   = |s_blk;
        any_err   = |s_err;
        any_wake  = |s_wake;
        mux_rdata = '0;
        mux_wdata = '0;
        mux_wtid  = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            mux_rdata = mux_rdata | s_rdata[i];
            mux_wdata = mux_wdata | s_wdata[i];
            mux_wtid  = mux_wtid  | s_wtid[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_valid   <= 1'b0;
            resp_done    <= 1'b0;
            resp_blocked <= 1'b0;
            resp_err     <= 1'b0;
            resp_data    <= '0;
            wake_valid   <= 1'b0;
            wake_tid     <= '0;
            wake_data    <= '0;
        end else begin
            resp_valid   <= req_valid;
            resp_done    <= any_done;
            resp_blocked <= any_blk;
            resp_err     <= req_valid && (!idx_ok || any_err);
            resp_data    <= mux_rdata;
            wake_valid   <= any_wake;
            wake_tid     <= mux_wtid;
            wake_data    <= mux_wdata;
        end
    end

    p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> ($countones({resp_done, resp_blocked, resp_err}) == 1));
    p_idle_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |-> !(resp_done || resp_blocked || resp_err || wake_valid));
    p_wake_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid |-> resp_done);
    p_err_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        resp_err |-> ($stable(ch_full) && $stable(ch_waiter)));
    p_one_select_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

endmodule

// File: tb/sim_msgchan_bank.sv
module sim_msgchan_bank;
    localparam int NCH = 4;
    localparam int DW  = 8;
    localparam int TW  = 4;
    localparam int WQ  = 2;
    localparam int CW  = $clog2(NCH) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_out = 1'b0;
    logic [CW-1:0] req_ch = '0;
    logic [TW-1:0] req_tid = '0;
    logic [DW-1:0] req_data = '0;
    logic          resp_valid, resp_done, resp_blocked, resp_err, wake_valid;
    logic [DW-1:0] resp_data, wake_data;
    logic [TW-1:0] wake_tid;
    logic [NCH-1:0] ch_full, ch_waiter;

    always #10 clk = ~clk;

    msgchan_bank #(.NUM_CH(NCH), .DATA_W(DW), .TID_W(TW), .WQ_DEPTH(WQ)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_out(req_out),
        .req_ch(req_ch), .req_tid(req_tid), .req_data(req_data),
        .resp_valid(resp_valid), .resp_done(resp_done), .resp_blocked(resp_blocked),
        .resp_err(resp_err), .resp_data(resp_data), .wake_valid(wake_valid),
        .wake_tid(wake_tid), .wake_data(wake_data), .ch_full(ch_full), .ch_waiter(ch_waiter)
    );

    int checks = 0, failures = 0, cycles = 0;
    bit finished = 0;

    // behavioural model
    bit m_full [NCH];
    int m_held [NCH];
    bit m_rdw  [NCH];
    int m_rdt  [NCH];
    int m_wn   [NCH];
    int m_wt   [NCH][WQ];
    int m_wd   [NCH][WQ];

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // one cycle: present request, predict, compare after the edge
    task automatic step(string tag, bit v, bit o, int ch, int tid, int d);
        int e_done = 0, e_blk = 0, e_err = 0, e_rd = 0, e_wk = 0, e_wt = 0, e_wd = 0;
        int e_full = 0, e_wait = 0;
        req_valid = v; req_out = o; req_ch = CW'(ch); req_tid = TW'(tid); req_data = DW'(d);
        if (v) begin
            if (ch >= NCH) e_err = 1;
            else if (o) begin
                if (m_rdw[ch]) begin
                    e_done = 1; e_wk = 1; e_wt = m_rdt[ch]; e_wd = d; m_rdw[ch] = 0;
                end else if (!m_full[ch]) begin
                    e_done = 1; m_full[ch] = 1; m_held[ch] = d;
                end else if (m_wn[ch] < WQ) begin
                    e_blk = 1; m_wt[ch][m_wn[ch]] = tid; m_wd[ch][m_wn[ch]] = d; m_wn[ch]++;
                end else e_err = 1;
            end else begin
                if (m_full[ch]) begin
                    e_done = 1; e_rd = m_held[ch];
                    if (m_wn[ch] > 0) begin
                        e_wk = 1; e_wt = m_wt[ch][0]; e_wd = 0; m_held[ch] = m_wd[ch][0];
                        for (int k = 0; k < WQ - 1; k++) begin
                            m_wt[ch][k] = m_wt[ch][k+1]; m_wd[ch][k] = m_wd[ch][k+1];
                        end
                        m_wn[ch]--;
                    end else m_full[ch] = 0;
                end else if (!m_rdw[ch]) begin
                    e_blk = 1; m_rdw[ch] = 1; m_rdt[ch] = tid;
                end else e_err = 1;
            end
        end
        for (int c = 0; c < NCH; c++) begin
            if (m_full[c]) e_full |= (1 << c);
            if (m_rdw[c] || m_wn[c] > 0) e_wait |= (1 << c);
        end
        @(posedge clk);
        #1;
        chk(tag, "resp_valid", int'(resp_valid), int'(v));
        chk(tag, "outcome", int'({resp_done, resp_blocked, resp_err}), (e_done << 2) | (e_blk << 1) | e_err);
        chk(tag, "resp_data", int'(resp_data), e_rd);
        chk(tag, "wake", int'({wake_valid, wake_tid, wake_data}), (e_wk << (TW + DW)) | (e_wt << DW) | e_wd);
        chk(tag, "status", int'({ch_waiter, ch_full}), (e_wait << NCH) | e_full);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected<100000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            m_full[c] = 0; m_held[c] = 0; m_rdw[c] = 0; m_rdt[c] = 0; m_wn[c] = 0;
        end
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        chk("R10", "outputs", int'({resp_valid, resp_done, resp_blocked, resp_err, wake_valid}), 0);
        chk("R10", "status", int'({ch_waiter, ch_full}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        step("R10", 0, 0, 0, 0, 0);

        // writers pile up on channel 0 and drain in arrival order
        step("R1", 1, 1, 0, 1, 'hA5);
        step("R2", 1, 1, 0, 2, 'h11);
        step("R2", 1, 1, 0, 3, 'h22);
        step("R8", 1, 1, 0, 4, 'h33);
        step("R6", 1, 0, 0, 5, 0);
        step("R6", 1, 0, 0, 6, 0);
        step("R3", 1, 0, 0, 7, 0);
        // reader first on channel 1
        step("R4", 1, 0, 1, 8, 0);
        step("R8", 1, 0, 1, 9, 0);
        step("R5", 1, 1, 1, 10, 'h3C);
        // invalid indices
        step("R7", 1, 1, 5, 1, 'h77);
        step("R7", 1, 0, 4, 2, 0);
        // lock on channel 2, with channel 3 traffic interleaved
        step("R1", 1, 1, 2, 1, 'h01);
        step("R2", 1, 1, 2, 2, 'h02);
        step("R1", 1, 1, 3, 9, 'h99);
        step("R7", 1, 1, 6, 3, 'h55);
        step("R6", 1, 0, 2, 1, 0);
        step("R3", 1, 0, 2, 2, 0);
        step("R3", 1, 0, 3, 9, 0);
        step("R9", 0, 1, 2, 0, 0);

        // mixed random traffic
        for (int n = 0; n < 400; n++) begin
            step("R9", ($urandom % 4) != 0, $urandom % 2, $urandom % (NCH + 2),
                 $urandom % 16, $urandom % 256);
        end
        finish_run();
    end
endmodule